// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the coherence controller of one processor's private, direct-mapped cache on a shared bus. Every line holds a tag, one data byte and three independent status flags: valid, dirty (the byte differs from main memory) and shared (another cache may hold a copy). Processor reads and writes are served from the line when possible. Otherwise the controller asks for the bus, issues a broadcast request and installs the line when the bus response arrives. A dirty line that is about to be replaced is first written back to memory.

At the same time the controller watches the requests other caches put on the bus. A read by another cache that hits here raises a shared indication. If the hit line is dirty, the controller also drives the byte onto the bus and marks its copy clean and shared. An invalidating request that hits here drops the local copy. Main memory, or a cache that supplies data, answers this controller's own requests on a single response strobe. That strobe carries the fill byte and the wired-OR shared indication of the other caches. A snoop and a response never occur in the same cycle.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After synchronous reset every line is invalid, and cpu_ready, bus_req, bus_cmd, snp_shared and snp_supply are all 0.
- R2: A read miss requests the bus and, one cycle after the grant, shows command read (bus_cmd=01) with address {tag,index} for exactly one cycle. When the response arrives the line is filled valid and clean. Its shared flag is set equal to bus_resp_shared, and cpu_rdata returns the response byte with cpu_ready.
- R3: A read hit returns the stored byte with a one-cycle cpu_ready pulse in the cycle after acceptance, with no bus activity.
- R4: A write hit on a line whose shared flag is 0 stores the byte and sets the dirty flag without any bus activity.
- R5: A write hit on a line whose shared flag is 1 issues an invalidating command (bus_cmd=10) for that address. After the response the line is valid, dirty and not shared, and holds the new byte.
- R6: A write miss issues an invalidating command (bus_cmd=10) for the address and ignores the response byte. The line ends valid, dirty and not shared, holding the written byte.
- R7: A miss whose index holds a valid dirty line first issues a write-back (bus_cmd=11) with the old address {old tag,index} on bus_addr and the old byte on bus_wdata. It waits for that response, then issues the request for the new address.
- R8: A snooped read (snp_cmd=01) that hits a valid line raises snp_shared in the next cycle and leaves the line valid and shared. If the line was dirty, snp_supply and snp_data carry its byte in that cycle and the line becomes clean.
- R9: A snooped invalidating command (snp_cmd=10) that hits clears the line's valid flag and raises neither snp_shared nor snp_supply.
- R10: A snoop that misses, and any snooped write-back (snp_cmd=11), produces no response and changes no line.
- R11: A processor request presented in a cycle with snp_valid high is not accepted in that cycle. It completes after the snoop has been served.
- R12: bus_req stays high until bus_gnt is seen. Each issued command appears on bus_cmd for exactly one cycle, in the cycle after the grant, and bus_cmd is 00 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 6 | Processor address {tag,index} |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read result, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Issued command: 00 none, 01 read, 10 invalidate, 11 write-back |
| bus_addr | output | 6 | Issued address |
| bus_wdata | output | 8 | Write-back byte |
| bus_resp_valid | input | 1 | Response strobe for the issued command |
| bus_resp_data | input | 8 | Fill byte from memory or a supplying cache |
| bus_resp_shared | input | 1 | Wired-OR shared indication of the other caches |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | 6 | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped read line |
| snp_supply | output | 1 | This cache drives dirty data for the snooped read |
| snp_data | output | 8 | Supplied byte |

## Verification
The bench sweeps an interleaved sequence of processor reads and writes and snooped commands over three tags and all four indices. A reference model predicts every bus command, address, write-back byte, read result and snoop response. The sweep exposes a controller that forgets to clear the dirty flag after supplying data, because that would produce a spurious write-back at the next eviction. It also exposes one that leaves the shared flag set after an upgrade, which would issue a second invalidation on the next write. A stale line after a snooped invalidation would show up as a read hit without a bus read. Grant delays of zero to two cycles catch a request that is dropped early or a command held too long. A directed collision of a snoop with a read hit catches a controller that lets the processor win.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_WB   = 2'b11
  } bus_cmd_e;
endpackage

// File: rtl/scc_store.sv
module scc_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  // processor-side read port
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_v,
  output logic              ra_d,
  output logic              ra_s,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  // snoop-side read port
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_v,
  output logic              rb_d,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  // full line write from the miss sequencer (always leaves the line valid)
  input  logic              fw_en,
  input  logic [IDX_W-1:0]  fw_idx,
  input  logic [TAG_W-1:0]  fw_tag,
  input  logic [DATA_W-1:0] fw_data,
  input  logic              fw_d,
  input  logic              fw_s,
  // status-only write from the snoop unit (wins on the same index)
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_v,
  input  logic              sw_d,
  input  logic              sw_s
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  v_q, d_q, s_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  // Flags need reset; tag and data arrays do not, so they map to plain RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      d_q <= '0;
      s_q <= '0;
    end else begin
      if (fw_en) begin
        v_q[fw_idx] <= 1'b1;
        d_q[fw_idx] <= fw_d;
        s_q[fw_idx] <= fw_s;
      end
      if (sw_en) begin
        v_q[sw_idx] <= sw_v;
        d_q[sw_idx] <= sw_d;
        s_q[sw_idx] <= sw_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fw_en) begin
      tag_mem[fw_idx]  <= fw_tag;
      data_mem[fw_idx] <= fw_data;
    end
  end

  assign ra_v    = v_q[ra_idx];
  assign ra_d    = d_q[ra_idx];
  assign ra_s    = s_q[ra_idx];
  assign ra_tag  = tag_mem[ra_idx];
  assign ra_data = data_mem[ra_idx];
  assign rb_v    = v_q[rb_idx];
  assign rb_d    = d_q[rb_idx];
  assign rb_tag  = tag_mem[rb_idx];
  assign rb_data = data_mem[rb_idx];

  // R9: an invalidating status write leaves the line invalid afterwards
  a_r9_inval_sticks: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !sw_v) |=> !v_q[$past(sw_idx)]);
  // R6: a line write always yields a valid line
  a_r6_fill_valid: assert property (@(posedge clk) disable iff (rst)
    (fw_en && !(sw_en && sw_idx == fw_idx)) |=> v_q[$past(fw_idx)]);
endmodule

// File: rtl/scc_snoop.sv
module scc_snoop
  import scc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr,
  output logic [IDX_W-1:0]        rb_idx,
  input  logic                    rb_v,
  input  logic                    rb_d,
  input  logic [TAG_W-1:0]        rb_tag,
  input  logic [DATA_W-1:0]       rb_data,
  output logic                    sw_en,
  output logic [IDX_W-1:0]        sw_idx,
  output logic                    sw_v,
  output logic                    sw_d,
  output logic                    sw_s,
  output logic                    snp_shared,
  output logic                    snp_supply,
  output logic [DATA_W-1:0]       snp_data
);
  logic hit, is_rd, is_rdx;

  assign rb_idx = snp_addr[IDX_W-1:0];
  assign hit    = snp_valid && rb_v && (rb_tag == snp_addr[TAG_W+IDX_W-1:IDX_W]);
  assign is_rd  = (snp_cmd == CMD_RD);
  assign is_rdx = (snp_cmd == CMD_RDX);

  // A read hit keeps the line as clean and shared; an invalidation drops it.
  assign sw_en  = hit && (is_rd || is_rdx);
  assign sw_idx = rb_idx;
  assign sw_v   = is_rd;
  assign sw_d   = 1'b0;
  assign sw_s   = is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared <= 1'b0;
      snp_supply <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_shared <= hit && is_rd;
      snp_supply <= hit && is_rd && rb_d;
      snp_data   <= (hit && is_rd && rb_d) ? rb_data : '0;
    end
  end

  // R8: data is only supplied together with the shared indication
  a_r8_supply_with_shared: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_shared);
  // R10: a snooped write-back never gets a response
  a_r10_wb_silent: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == CMD_WB) |=> (!snp_shared && !snp_supply));
  // R9: an invalidating snoop never gets a response
  a_r9_rdx_silent: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == CMD_RDX) |=> !snp_shared);
endmodule

// File: rtl/scc_master.sv
module scc_master
  import scc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [TAG_W+IDX_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_resp_valid,
  input  logic [DATA_W-1:0]       bus_resp_data,
  input  logic                    bus_resp_shared,
  output logic [IDX_W-1:0]        ra_idx,
  input  logic                    ra_v,
  input  logic                    ra_d,
  input  logic                    ra_s,
  input  logic [TAG_W-1:0]        ra_tag,
  input  logic [DATA_W-1:0]       ra_data,
  output logic                    fw_en,
  output logic [IDX_W-1:0]        fw_idx,
  output logic [TAG_W-1:0]        fw_tag,
  output logic [DATA_W-1:0]       fw_data,
  output logic                    fw_d,
  output logic                    fw_s
);
  localparam int ADDR_W = TAG_W + IDX_W;

  typedef enum logic [2:0] {ST_IDLE, ST_WB_REQ, ST_WB_WAIT, ST_REQ, ST_WAIT} state_e;

  state_e              state;
  logic                op_we;
  logic [ADDR_W-1:0]   op_addr;
  logic [DATA_W-1:0]   op_wdata;
  logic [1:0]          pend_cmd;
  logic                ready_q, req_q;
  logic [1:0]          cmd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                accept, hit;

  assign ra_idx = (state == ST_IDLE) ? cpu_addr[IDX_W-1:0] : op_addr[IDX_W-1:0];
  // A snoop in the same cycle takes precedence over the processor.
  assign accept = (state == ST_IDLE) && cpu_req && !snp_valid && !ready_q;
  assign hit    = ra_v && (ra_tag == cpu_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    fw_en   = 1'b0;
    fw_idx  = op_addr[IDX_W-1:0];
    fw_tag  = op_addr[ADDR_W-1:IDX_W];
    fw_data = op_we ? op_wdata : bus_resp_data;
    fw_d    = op_we;
    fw_s    = !op_we && bus_resp_shared;
    if (accept && hit && cpu_we && !ra_s) begin
      fw_en   = 1'b1;
      fw_idx  = cpu_addr[IDX_W-1:0];
      fw_tag  = cpu_addr[ADDR_W-1:IDX_W];
      fw_data = cpu_wdata;
      fw_d    = 1'b1;
      fw_s    = 1'b0;
    end else if (state == ST_WAIT && bus_resp_valid) begin
      fw_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      pend_cmd <= CMD_NONE;
      ready_q  <= 1'b0;
      req_q    <= 1'b0;
      cmd_q    <= CMD_NONE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      ready_q <= 1'b0;
      cmd_q   <= CMD_NONE;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_we    <= cpu_we;
          op_addr  <= cpu_addr;
          op_wdata <= cpu_wdata;
          if (hit && !(cpu_we && ra_s)) begin
            ready_q <= 1'b1;
            if (!cpu_we) rdata_q <= ra_data;
          end else begin
            pend_cmd <= (cpu_we) ? CMD_RDX : CMD_RD;
            req_q    <= 1'b1;
            state    <= (!hit && ra_v && ra_d) ? ST_WB_REQ : ST_REQ;
          end
        end
        ST_WB_REQ: if (bus_gnt) begin
          req_q   <= 1'b0;
          cmd_q   <= CMD_WB;
          addr_q  <= {ra_tag, op_addr[IDX_W-1:0]};
          wdata_q <= ra_data;
          state   <= ST_WB_WAIT;
        end
        ST_WB_WAIT: if (bus_resp_valid) begin
          req_q <= 1'b1;
          state <= ST_REQ;
        end
        ST_REQ: if (bus_gnt) begin
          req_q   <= 1'b0;
          cmd_q   <= pend_cmd;
          addr_q  <= op_addr;
          wdata_q <= '0;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (bus_resp_valid) begin
          ready_q <= 1'b1;
          if (!op_we) rdata_q <= bus_resp_data;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = req_q;
  assign bus_cmd   = cmd_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R12: a command occupies the bus for a single cycle
  a_r12_cmd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != CMD_NONE) |=> (bus_cmd == CMD_NONE));
  // R12: the request is held until granted
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);
  // R11: no completion in the cycle after a snoop collides with an idle controller
  a_r11_snoop_first: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && snp_valid && !cpu_ready) |=> !cpu_ready);
  // R3: completion is a single-cycle pulse
  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic [1:0]              bus_cmd,
  output logic [TAG_W+IDX_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_resp_valid,
  input  logic [DATA_W-1:0]       bus_resp_data,
  input  logic                    bus_resp_shared,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr,
  output logic                    snp_shared,
  output logic                    snp_supply,
  output logic [DATA_W-1:0]       snp_data
);
  logic [IDX_W-1:0]  ra_idx, rb_idx, fw_idx, sw_idx;
  logic              ra_v, ra_d, ra_s, rb_v, rb_d;
  logic [TAG_W-1:0]  ra_tag, rb_tag, fw_tag;
  logic [DATA_W-1:0] ra_data, rb_data, fw_data;
  logic              fw_en, fw_d, fw_s, sw_en, sw_v, sw_d, sw_s;

  scc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_v(ra_v), .ra_d(ra_d), .ra_s(ra_s), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_v(rb_v), .rb_d(rb_d), .rb_tag(rb_tag), .rb_data(rb_data),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_tag(fw_tag), .fw_data(fw_data), .fw_d(fw_d), .fw_s(fw_s),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_v(sw_v), .sw_d(sw_d), .sw_s(sw_s)
  );

  scc_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .rb_idx(rb_idx), .rb_v(rb_v), .rb_d(rb_d), .rb_tag(rb_tag), .rb_data(rb_data),
    .sw_en(sw_en), .sw_idx(sw_idx), .sw_v(sw_v), .sw_d(sw_d), .sw_s(sw_s),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  scc_master #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_master (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
    .bus_resp_shared(bus_resp_shared),
    .ra_idx(ra_idx), .ra_v(ra_v), .ra_d(ra_d), .ra_s(ra_s), .ra_tag(ra_tag), .ra_data(ra_data),
    .fw_en(fw_en), .fw_idx(fw_idx), .fw_tag(fw_tag), .fw_data(fw_data), .fw_d(fw_d), .fw_s(fw_s)
  );
endmodule

// File: tb/sim_snoop_cache_ctrl.sv
module sim_snoop_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 2, TAG_W = 4, DATA_W = 8;
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, bus_resp_data = '0;
  logic cpu_ready, bus_req, snp_shared, snp_supply;
  logic [DATA_W-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [1:0] bus_cmd, snp_cmd = 2'b00;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 0, bus_resp_valid = 0, bus_resp_shared = 0, snp_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_cache_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
    .bus_resp_shared(bus_resp_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model
  logic mv[LINES], md[LINES], ms[LINES];
  logic [TAG_W-1:0]  mt[LINES];
  logic [DATA_W-1:0] mdat[LINES];
  logic [DATA_W-1:0] mem[1 << ADDR_W];

  // record of the last processor operation
  int rc_n, rc_cyc;
  logic [1:0] rc_cmd[2];
  logic [ADDR_W-1:0] rc_addr[2];
  logic [DATA_W-1:0] rc_wd[2];
  logic [DATA_W-1:0] rc_rdata;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input logic shr, input int gdly);
    int waited = 0;
    bit prev_cmd = 0, gave = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    rc_n = 0; rc_cyc = -1;
    for (int cyc = 0; cyc < 100; cyc++) begin
      @(negedge clk);
      bus_gnt = 0; bus_resp_valid = 0;
      if (cpu_ready) begin rc_cyc = cyc; break; end
      if (gave) chk(bus_cmd != 2'b00, "R12", "command after grant", bus_cmd, 1);
      gave = 0;
      if (bus_cmd != 2'b00) begin
        if (prev_cmd) chk(0, "R12", "command held two cycles", bus_cmd, 0);
        prev_cmd = 1;
        if (rc_n < 2) begin
          rc_cmd[rc_n] = bus_cmd; rc_addr[rc_n] = bus_addr; rc_wd[rc_n] = bus_wdata;
        end
        rc_n++;
        bus_resp_shared = 0;
        if (bus_cmd == 2'b01) begin
          bus_resp_data = mem[bus_addr]; bus_resp_shared = shr;
        end else begin
          if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
          bus_resp_data = 8'hA5;
        end
        bus_resp_valid = 1;
      end else begin
        prev_cmd = 0;
        if (bus_req) begin
          if (waited >= gdly) begin bus_gnt = 1; gave = 1; waited = 0; end
          else waited++;
        end
      end
    end
    rc_rdata = cpu_rdata;
    cpu_req = 0;
  endtask

  task automatic do_cpu(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input logic shr, input int gdly);
    int idx = int'(a[IDX_W-1:0]);
    logic [TAG_W-1:0] tg = a[ADDR_W-1:IDX_W];
    bit hit = mv[idx] && mt[idx] == tg;
    int en = 1;
    logic [1:0] ec0 = we ? 2'b10 : 2'b01, ec1 = 2'b00;
    logic [ADDR_W-1:0] ea0 = a, ea1 = a;
    logic [DATA_W-1:0] ewb = mdat[idx];
    logic [DATA_W-1:0] erd = hit ? mdat[idx] : mem[a];
    string tag;
    if (hit && !(we && ms[idx])) begin en = 0; tag = we ? "R4" : "R3"; end
    else if (hit) tag = "R5";
    else if (mv[idx] && md[idx]) begin
      en = 2; ec1 = ec0; ea1 = a; ec0 = 2'b11; ea0 = {mt[idx], a[IDX_W-1:0]}; tag = "R7";
    end else tag = we ? "R6" : "R2";
    cpu_op(we, a, wd, shr, gdly);
    chk(rc_cyc >= 0, tag, "completion seen", rc_cyc, 0);
    chk(rc_n == en, tag, "bus command count", rc_n, en);
    if (en == 0) chk(rc_cyc == 0, tag, "hit latency", rc_cyc, 0);
    if (en >= 1 && rc_n >= 1) begin
      chk(rc_cmd[0] == ec0, tag, "first command", rc_cmd[0], ec0);
      chk(rc_addr[0] == ea0, tag, "first address", rc_addr[0], ea0);
      if (en == 2) chk(rc_wd[0] == ewb, "R7", "write-back byte", rc_wd[0], ewb);
    end
    if (en == 2 && rc_n >= 2) begin
      chk(rc_cmd[1] == ec1, "R7", "request after write-back", rc_cmd[1], ec1);
      chk(rc_addr[1] == ea1, "R7", "request address", rc_addr[1], ea1);
    end
    if (!we) chk(rc_rdata == erd, tag, "read byte", rc_rdata, erd);
    mv[idx] = 1; mt[idx] = tg;
    if (we) begin md[idx] = 1; ms[idx] = 0; mdat[idx] = wd; end
    else if (!hit) begin md[idx] = 0; ms[idx] = shr; mdat[idx] = erd; end
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
    int idx = int'(a[IDX_W-1:0]);
    bit hit = mv[idx] && mt[idx] == a[ADDR_W-1:IDX_W];
    bit esh = (cmd == 2'b01) && hit;
    bit esu = esh && md[idx];
    string tag = (!hit || cmd == 2'b11) ? "R10" : (cmd == 2'b01 ? "R8" : "R9");
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk(snp_shared == esh, tag, "snp_shared", snp_shared, esh);
    chk(snp_supply == esu, tag, "snp_supply", snp_supply, esu);
    if (esu) chk(snp_data == mdat[idx], "R8", "supplied byte", snp_data, mdat[idx]);
    if (esh) begin
      if (esu) mem[a] = mdat[idx];
      md[idx] = 0; ms[idx] = 1;
    end else if (hit && cmd == 2'b10) mv[idx] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < LINES; i++) begin
      mv[i] = 0; md[i] = 0; ms[i] = 0; mt[i] = '0; mdat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(cpu_ready == 0 && bus_req == 0, "R1", "ready/req after reset", {cpu_ready, bus_req}, 0);
    chk(bus_cmd == 2'b00, "R1", "bus_cmd after reset", bus_cmd, 0);
    chk(snp_shared == 0 && snp_supply == 0, "R1", "snoop outputs after reset", {snp_shared, snp_supply}, 0);
    // R1: every line invalid (a snooped read of tag 0 gets no answer)
    for (int k = 0; k < LINES; k++) do_snoop(2'b01, ADDR_W'(k));

    // directed: shared fill, upgrade, supply, invalidate
    do_cpu(0, {4'd7, 2'd1}, 8'h00, 1, 0);   // R2 fill with shared set
    do_cpu(1, {4'd7, 2'd1}, 8'h3C, 0, 1);   // R5 upgrade
    do_cpu(1, {4'd7, 2'd1}, 8'h3D, 0, 0);   // R4 exclusive write hit
    do_snoop(2'b01, {4'd7, 2'd1});          // R8 dirty supply
    do_snoop(2'b10, {4'd7, 2'd1});          // R9 invalidate
    do_cpu(0, {4'd7, 2'd1}, 8'h00, 0, 2);   // R2 miss after invalidation

    // sweep
    for (int i = 0; i < 400; i++) begin
      int k = (i * 5 + 3) % 7;
      logic [ADDR_W-1:0] a = {4'((i * 3 + i / 4) % 3), 2'((i + i / 3) % 4)};
      case (k)
        0, 1: do_cpu(0, a, 8'h00, (i % 3) == 0, i % 3);
        2, 3: do_cpu(1, a, 8'(i * 13 + 7), 0, i % 3);
        4:    do_snoop(2'b01, a);
        5:    do_snoop(2'b10, a);
        default: do_snoop(2'b11, a);
      endcase
    end

    // R11: snoop and processor read hit in the same cycle
    do_cpu(0, {4'd9, 2'd2}, 8'h00, 0, 0);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = {4'd9, 2'd2};
    snp_valid = 1; snp_cmd = 2'b01; snp_addr = {4'd15, 2'd3};
    @(negedge clk);
    snp_valid = 0;
    chk(cpu_ready == 0, "R11", "processor held during snoop", cpu_ready, 0);
    chk(snp_shared == 0, "R11", "snoop miss answered", snp_shared, 0);
    @(negedge clk);
    chk(cpu_ready == 1, "R11", "processor served after snoop", cpu_ready, 1);
    chk(cpu_rdata == mdat[2], "R11", "read byte after snoop", cpu_rdata, mdat[2]);
    cpu_req = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule